// File: doc/BRIEF.md
# Radix-4 Word-Serial Montgomery Multiplier

This block forms the Montgomery product Z ≡ X·Y·2^-n (mod M) for an odd modulus M. The precision is n = nwords·W bits. The datapath is a fixed W-bit word slice, so one kernel serves every precision up to MAXW words.

The multiplier X is taken two bits per iteration. Each pair is Booth-recoded into a signed digit in {-2..2}. That digit selects a shifted and/or complemented copy of Y. A signed quotient digit in {-1,0,1,2} is chosen so that the two lowest bits of the partial sum cancel. That digit selects a shifted and/or complemented copy of M. The sum is then shifted right by two bits, so no divider and no stored 3·M are needed.

The partial sum stays a signed two's complement value with magnitude below 2M. A result can therefore be fed straight back as X or Y of the next product, with no correcting subtraction.

A run has three phases, each paced by a strobe from the block:
- Load: after a start pulse, the words of Y and M are taken least-significant word first.
- Compute: one X digit is taken per iteration, low digit first.
- Emit: the result comes out word by word, least-significant word first.

Top module: `mm4_mont_mul`

## Requirements
- R1: With M odd, M < 2^(n-2), and X, Y given as n-bit two's complement values with |X| < 2M and |Y| < 2M, the emitted n-bit signed result Z satisfies Z ≡ X·Y·2^-n (mod M). This holds for M ≡ 1 and for M ≡ 3 modulo 4.
- R2: Under the conditions of R1, the result read as an n-bit two's complement value satisfies -2M < Z < 2M.
- R3: A run takes exactly n/2 digits on x_dig, one in each cycle where x_take is high. Digit i is bits [2i+1:2i] of X's n-bit pattern, taken in increasing order of i.
- R4: A start accepted in idle is followed by exactly nwords consecutive cycles with ym_take high. In the j-th of those cycles (j from 0), y_word and m_word carry bits [jW+W-1:jW] of Y and M.
- R5: res_valid is high for exactly nwords consecutive cycles, least-significant word first. done is high together with the last word only. done appears in the (2·nwords + (n/2)·(nwords+1))-th cycle after the clock edge that accepted start.
- R6: start and nwords are ignored while a run is in progress. Neither the result nor the timing of that run changes.
- R7: After reset, ym_take, x_take, res_valid and done are all low.
- R8: A start with nwords equal to 0 or greater than MAXW is ignored: no strobe rises.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Starts a run when idle |
| nwords | input | $clog2(MAXW+1) | Operand precision in W-bit words, sampled at start |
| ym_take | output | 1 | Block takes y_word and m_word this cycle |
| y_word | input | W | Multiplicand word |
| m_word | input | W | Modulus word |
| x_take | output | 1 | Block takes x_dig this cycle |
| x_dig | input | 2 | Next two bits of the multiplier |
| res_valid | output | 1 | res_word holds a result word |
| res_word | output | W | Result word, least significant first |
| done | output | 1 | High with the last result word |

## Verification
The hardest case to reach is a partial sum pushed close to its ±2M bound. Reaching it takes a long run of same-sign Booth digits against a modulus that is nearly a power of two. The bench gets there with operands at ±(2M-1), of opposite and equal signs, against a modulus of all ones. Random odd moduli at several precisions exercise both quotient rules. A start pulse with a different word count is also injected in the middle of a run.

// File: rtl/mm4_pkg.sv
`timescale 1ns/1ps
package mm4_pkg;

  typedef enum logic [1:0] {ST_IDLE, ST_LOAD, ST_CALC, ST_EMIT} mm4_state_e;

  // signed digit: magnitude 0..2 and a negate flag
  typedef struct packed {
    logic [1:0] mag;
    logic       neg;
  } sdig_t;

  // radix-4 Booth recode of {x_hi, x_lo, previous x_hi}
  function automatic sdig_t booth_dig(input logic [2:0] b);
    sdig_t d;
    case (b)
      3'b001, 3'b010: d = '{mag: 2'd1, neg: 1'b0};
      3'b011:         d = '{mag: 2'd2, neg: 1'b0};
      3'b100:         d = '{mag: 2'd2, neg: 1'b1};
      3'b101, 3'b110: d = '{mag: 2'd1, neg: 1'b1};
      default:        d = '{mag: 2'd0, neg: 1'b0};
    endcase
    return d;
  endfunction

  // quotient 0..3 mapped to {0,+1,+2,-1}
  function automatic sdig_t quot_dig(input logic [1:0] q);
    sdig_t d;
    case (q)
      2'd1:    d = '{mag: 2'd1, neg: 1'b0};
      2'd2:    d = '{mag: 2'd2, neg: 1'b0};
      2'd3:    d = '{mag: 2'd1, neg: 1'b1};
      default: d = '{mag: 2'd0, neg: 1'b0};
    endcase
    return d;
  endfunction

endpackage

// File: rtl/mm4_mult_sel.sv
`timescale 1ns/1ps
module mm4_mult_sel
  import mm4_pkg::*;
#(
  parameter int W = 8
) (
  input  logic [W-1:0] w_in,
  input  logic         low_fill,
  input  sdig_t        sel,
  output logic [W-1:0] w_out
);
  logic [W-1:0] base;

  always_comb begin
    case (sel.mag)
      2'd1:    base = w_in;
      2'd2:    base = {w_in[W-2:0], low_fill};
      default: base = '0;
    endcase
    w_out = sel.neg ? ~base : base;
  end
endmodule

// File: rtl/mm4_word_add.sv
`timescale 1ns/1ps
module mm4_word_add #(
  parameter int W = 8
) (
  input  logic [W-1:0] s_in,
  input  logic [W-1:0] a_in,
  input  logic [W-1:0] b_in,
  input  logic [1:0]   cin,
  output logic [W-1:0] sum,
  output logic [1:0]   cout
);
  logic [W+1:0] tot;

  always_comb begin
    tot  = {2'b00, s_in} + {2'b00, a_in} + {2'b00, b_in} + {{W{1'b0}}, cin};
    sum  = tot[W-1:0];
    cout = tot[W+1:W];
  end
endmodule

// File: rtl/mm4_mont_mul.sv
`timescale 1ns/1ps
module mm4_mont_mul
  import mm4_pkg::*;
#(
  parameter int W    = 8,
  parameter int MAXW = 8
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         start,
  input  logic [$clog2(MAXW+1)-1:0]    nwords,
  output logic                         ym_take,
  input  logic [W-1:0]                 y_word,
  input  logic [W-1:0]                 m_word,
  output logic                         x_take,
  input  logic [1:0]                   x_dig,
  output logic                         res_valid,
  output logic [W-1:0]                 res_word,
  output logic                         done
);
  localparam int IDX_W = $clog2(MAXW+1);
  localparam int DEPTH = 1 << IDX_W;
  localparam int IT_W  = $clog2(MAXW*W/2 + 1);
  localparam logic [IDX_W-1:0] ONE_I = 1;
  localparam logic [IDX_W-1:0] MAX_I = MAXW;

  mm4_state_e        state, state_n;
  logic [IDX_W-1:0]  widx, widx_n, nw_r, nw_n;
  logic [IT_W-1:0]   iter, iter_n;
  logic              xp_r, xp_n, ymsb_r, ymsb_n, mmsb_r, mmsb_n;
  logic [1:0]        carry_r, carry_n;
  logic [W-3:0]      lo_r, lo_n;
  sdig_t             d_r, d_n, q_r, q_n;

  logic [W-1:0] y_mem [DEPTH];
  logic [W-1:0] m_mem [DEPTH];
  logic [W-1:0] s_mem [DEPTH];

  logic [IDX_W-1:0] last_w, rd_idx;
  logic [IT_W-1:0]  iter_last;
  logic             in_range, first_w;
  logic [W-1:0]     s_rd, y_rd, m_rd, s_w, y_w, m_w, a_w, b_w, sum_w;
  logic [1:0]       cin, cout, t2, mp;
  logic [3:0]       qprod;
  sdig_t            dsel, qsel;

  assign last_w    = nw_r - ONE_I;
  assign iter_last = IT_W'(nw_r) * IT_W'(W/2) - IT_W'(1);
  assign in_range  = (widx < nw_r);
  assign rd_idx    = in_range ? widx : last_w;
  assign first_w   = (widx == '0);

  // operand words; the word above the top is sign (Y, S) or zero (M)
  assign s_rd = s_mem[rd_idx];
  assign y_rd = y_mem[rd_idx];
  assign m_rd = m_mem[rd_idx];
  assign s_w  = in_range ? s_rd : {W{s_rd[W-1]}};
  assign y_w  = in_range ? y_rd : {W{y_rd[W-1]}};
  assign m_w  = in_range ? m_rd : '0;

  // multiplier digit: taken live on the first word, held afterwards
  assign dsel = first_w ? booth_dig({x_dig, xp_r}) : d_r;

  mm4_mult_sel #(.W(W)) u_ysel (
    .w_in(y_w), .low_fill(first_w ? 1'b0 : ymsb_r), .sel(dsel), .w_out(a_w));

  // quotient digit from low bits of S + d*Y and -1/M mod 4
  assign t2    = s_w[1:0] + a_w[1:0] + {1'b0, dsel.neg};
  assign mp    = {~m_rd[1], 1'b1};
  assign qprod = {2'b00, t2} * {2'b00, mp};
  assign qsel  = first_w ? quot_dig(qprod[1:0]) : q_r;

  mm4_mult_sel #(.W(W)) u_msel (
    .w_in(m_w), .low_fill(first_w ? 1'b0 : mmsb_r), .sel(qsel), .w_out(b_w));

  assign cin = first_w ? ({1'b0, dsel.neg} + {1'b0, qsel.neg}) : carry_r;

  mm4_word_add #(.W(W)) u_add (
    .s_in(s_w), .a_in(a_w), .b_in(b_w), .cin(cin), .sum(sum_w), .cout(cout));

  assign ym_take   = (state == ST_LOAD);
  assign x_take    = (state == ST_CALC) && first_w;
  assign res_valid = (state == ST_EMIT);
  assign res_word  = s_mem[widx];
  assign done      = (state == ST_EMIT) && (widx == last_w);

  always_comb begin
    state_n = state;  widx_n = widx;   iter_n  = iter;    nw_n   = nw_r;
    xp_n    = xp_r;   d_n    = d_r;    q_n     = q_r;     carry_n = carry_r;
    ymsb_n  = ymsb_r; mmsb_n = mmsb_r; lo_n    = lo_r;
    case (state)
      ST_IDLE: if (start && nwords != '0 && nwords <= MAX_I) begin
        nw_n = nwords; widx_n = '0; state_n = ST_LOAD;
      end
      ST_LOAD: begin
        widx_n = widx + ONE_I;
        if (widx == last_w) begin
          widx_n = '0; iter_n = '0; xp_n = 1'b0; state_n = ST_CALC;
        end
      end
      ST_CALC: begin
        carry_n = cout;
        ymsb_n  = y_w[W-1];
        mmsb_n  = m_w[W-1];
        lo_n    = sum_w[W-1:2];
        if (first_w) begin
          d_n = dsel; q_n = qsel; xp_n = x_dig[1];
        end
        if (widx == nw_r) begin
          widx_n = '0;
          if (iter == iter_last) state_n = ST_EMIT;
          else                   iter_n  = iter + IT_W'(1);
        end else begin
          widx_n = widx + ONE_I;
        end
      end
      ST_EMIT: begin
        widx_n = widx + ONE_I;
        if (widx == last_w) begin
          widx_n = '0; state_n = ST_IDLE;
        end
      end
      default: state_n = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= ST_IDLE; widx <= '0; iter <= '0; nw_r <= ONE_I;
      xp_r <= 1'b0; d_r <= '0; q_r <= '0; carry_r <= '0;
      ymsb_r <= 1'b0; mmsb_r <= 1'b0; lo_r <= '0;
    end else begin
      state <= state_n; widx <= widx_n; iter <= iter_n; nw_r <= nw_n;
      xp_r <= xp_n; d_r <= d_n; q_r <= q_n; carry_r <= carry_n;
      ymsb_r <= ymsb_n; mmsb_r <= mmsb_n; lo_r <= lo_n;
    end
  end

  // operand store and in-place shifted write-back, one word behind the read
  always_ff @(posedge clk) begin
    if (state == ST_LOAD) begin
      y_mem[widx] <= y_word;
      m_mem[widx] <= m_word;
      s_mem[widx] <= '0;
    end else if (state == ST_CALC && !first_w) begin
      s_mem[widx - ONE_I] <= {sum_w[1:0], lo_r};
    end
  end

  // R1: the chosen quotient digit clears the two low bits before the shift
  p_low_bits_zero_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_CALC && first_w) |-> (sum_w[1:0] == 2'b00));

  // R1: three-operand word carry never exceeds two
  p_carry_bound_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_CALC && !first_w) |-> (carry_r != 2'b11));

  // R3: digits are taken at most once per iteration
  p_digit_spacing_r3: assert property (@(posedge clk) disable iff (!rst_n)
    x_take |=> !x_take);

  // R4: the first digit is requested right after the last loaded word
  p_load_then_digit_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ym_take) |-> x_take);

  // R5: done closes the result stream
  p_done_ends_r5: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> (!res_valid && !done));

  // R6: precision is frozen while busy
  p_len_frozen_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (state != ST_IDLE && state_n != ST_IDLE) |=> $stable(nw_r));
endmodule

// File: tb/mm4_mont_mul_tb_top.sv
`timescale 1ns/1ps
module mm4_mont_mul_tb_top;
  localparam int W     = 8;
  localparam int MAXW  = 8;
  localparam int IDX_W = $clog2(MAXW+1);

  logic             clk = 1'b0;
  logic             rst_n, start;
  logic [IDX_W-1:0] nwords;
  logic             ym_take, x_take, res_valid, done;
  logic [W-1:0]     y_word, m_word, res_word;
  logic [1:0]       x_dig;

  int n_checks = 0;
  int n_fails  = 0;

  always #5 clk = ~clk;

  mm4_mont_mul #(.W(W), .MAXW(MAXW)) dut_i (
    .clk(clk), .rst_n(rst_n), .start(start), .nwords(nwords),
    .ym_take(ym_take), .y_word(y_word), .m_word(m_word),
    .x_take(x_take), .x_dig(x_dig),
    .res_valid(res_valid), .res_word(res_word), .done(done));

  task automatic chk(input bit ok, input string req, input string what,
                     input logic signed [159:0] act, input logic signed [159:0] exp);
    n_checks++;
    if (!ok) begin
      n_fails++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  function automatic logic signed [159:0] ref_mont(input logic signed [159:0] xv,
      input logic signed [159:0] yv, input logic signed [159:0] mv, input int n);
    logic signed [159:0] t;
    t = (xv * yv) % mv;
    if (t < 0) t = t + mv;
    for (int i = 0; i < n; i++) t = t[0] ? ((t + mv) >>> 1) : (t >>> 1);
    return t;
  endfunction

  // one full product; poke >0 injects a start pulse at that cycle
  task automatic run_mul(input int nw, input logic signed [159:0] xv,
      input logic signed [159:0] yv, input logic signed [159:0] mv, input int poke);
    int n, k, cyc, li, xi, ri, dcyc;
    bit got;
    logic [159:0] res;
    logic signed [159:0] rs, rm, expv;
    n = nw * W; k = n / 2;
    cyc = 0; li = 0; xi = 0; ri = 0; dcyc = 0; got = 0; res = '0;
    @(negedge clk);
    nwords = IDX_W'(nw); start = 1'b1;
    while (!got && cyc < 6000) begin
      @(negedge clk);
      cyc++;
      start  = (poke > 0 && cyc == poke);
      nwords = (poke > 0 && cyc == poke) ? IDX_W'((nw % MAXW) + 1) : IDX_W'(nw);
      if (ym_take) begin
        y_word = yv[li*W +: W]; m_word = mv[li*W +: W]; li++;
      end
      if (x_take) begin
        x_dig = xv[2*xi +: 2]; xi++;
      end
      if (res_valid) begin
        res[ri*W +: W] = res_word; ri++;
      end
      if (done) begin
        got = 1; dcyc = cyc;
      end
    end
    start = 1'b0;
    chk(got, "R5", "watchdog: done never seen", 0, 1);
    chk(li == nw, "R4", "load word count", li, nw);
    chk(xi == k, "R3", "digit count", xi, k);
    chk(ri == nw, "R5", "result word count", ri, nw);
    chk(dcyc == 2*nw + k*(nw+1), "R5", "done cycle", dcyc, 2*nw + k*(nw+1));
    rs = res;
    if (res[n-1]) rs = rs - (160'sd1 <<< n);
    rm = rs % mv;
    if (rm < 0) rm = rm + mv;
    expv = ref_mont(xv, yv, mv, n);
    chk(rm == expv, "R1", "result residue", rm, expv);
    chk(rs < 2*mv && rs > -2*mv, "R2", "result bound", rs, 2*mv);
    if (poke > 0) chk(got && dcyc == 2*nw + k*(nw+1), "R6", "timing with mid-run start",
                      dcyc, 2*nw + k*(nw+1));
    @(negedge clk);
    chk(!res_valid && !done, "R5", "stream closed after done", res_valid, 0);
  endtask

  function automatic logic signed [159:0] rnd_mod(input int n);
    logic signed [159:0] m;
    m = {64'd0, $urandom, $urandom, $urandom};
    m = (m & ((160'sd1 <<< (n-2)) - 1)) | 1;
    if (m < 3) m = 3;
    return m;
  endfunction

  function automatic logic signed [159:0] rnd_op(input logic signed [159:0] m);
    logic signed [159:0] r;
    r = {64'd0, $urandom, $urandom, $urandom};
    return (r % (4*m - 1)) - (2*m - 1);
  endfunction

  task automatic t_reset;
    chk(!ym_take && !x_take && !res_valid && !done, "R7", "strobes after reset",
        {ym_take, x_take, res_valid, done}, 0);
  endtask

  task automatic t_small_mod1;   // M = 1 mod 4
    run_mul(1, 7, 11, 45, 0);
    run_mul(1, -60, 59, 45, 0);
  endtask

  task automatic t_small_mod3;   // M = 3 mod 4
    run_mul(1, -20, 33, 51, 0);
    run_mul(1, 0, 17, 63, 0);
  endtask

  task automatic t_extremes;
    logic signed [159:0] m;
    m = 16383;
    run_mul(2, -(2*m-1), 2*m-1, m, 0);
    run_mul(2, 2*m-1, 2*m-1, m, 0);
    run_mul(2, -(2*m-1), -(2*m-1), m, 0);
    m = (160'sd1 <<< 62) - 1;
    run_mul(8, 2*m-1, -(2*m-1), m, 0);
  endtask

  task automatic t_random;
    logic signed [159:0] m;
    int lens[6] = '{1, 2, 3, 4, 6, 8};
    foreach (lens[i]) begin
      for (int r = 0; r < 4; r++) begin
        m = rnd_mod(lens[i] * W);
        run_mul(lens[i], rnd_op(m), rnd_op(m), m, 0);
      end
    end
  endtask

  task automatic t_start_ignored;
    logic signed [159:0] m;
    m = rnd_mod(4 * W);
    run_mul(4, rnd_op(m), rnd_op(m), m, 20);
  endtask

  task automatic t_bad_len;      // R8
    bit seen;
    for (int v = 0; v < 2; v++) begin
      seen = 0;
      @(negedge clk);
      nwords = (v == 0) ? '0 : IDX_W'(MAXW + 1);
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      for (int c = 0; c < 6; c++) begin
        if (ym_take || x_take || res_valid || done) seen = 1;
        @(negedge clk);
      end
      chk(!seen, "R8", "out-of-range length ignored", seen, 0);
    end
  endtask

  initial begin
    #1_500_000;
    n_fails++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fails);
    $finish;
  end

  initial begin
    rst_n = 1'b0; start = 1'b0; nwords = '0;
    y_word = '0; m_word = '0; x_dig = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_bad_len();
    t_small_mod1();
    t_small_mod3();
    t_extremes();
    t_start_ignored();
    t_random();
    $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fails);
    $finish;
  end
endmodule